// File: doc/BRIEF.md
# Sense-Resistor Short Detector

This block watches a switching converter's gate pulses and finds a current-sense resistor that has been shorted, for example by a solder bridge. During each on-pulse it takes one look at the digitised sense level. That look happens a fixed number of clock cycles after the gate rises. A sense level that stays very low while the switch is conducting means the resistor carries no voltage, so the sample counts as a failure. The failure threshold depends on the line voltage. It is 50 mV at a 122 V DC bus and 100 mV at a 366 V DC bus, with a straight line between those two points. Outside that range it is held at the nearer endpoint.

A run of consecutive failing samples sets a fault. The fault blocks the gate output in the same clock cycle and stays set until the active-low reset is applied. A pulse that ends before its sample point is not judged at all. One passing sample clears the run.

Line voltage enters as a code in volts and sense level as a code in millivolts. The fault output goes to a supervisor outside this block.

Top module: `sense_short_guard`

## Requirements
- R1: While `rst_n` is low and after it is released, `fault_o` is 0 until a fault is detected.
- R2: A sample is taken in the clock cycle that lies SAMPLE_DLY cycles after the first cycle in which `gate_i` is high. A pulse that is high for SAMPLE_DLY+1 cycles is therefore judged.
- R3: `fault_o` rises after RUN_LEN consecutive failing samples (default 11) and not after RUN_LEN-1.
- R4: A passing sample (sense_mv_i >= threshold) resets the run of failing samples to zero.
- R5: A pulse that is high for SAMPLE_DLY cycles or fewer is neither counted nor allowed to reset the run.
- R6: For a line code L between 122 and 366, the threshold in mV is 50 + floor((L-122)*50/244). A sample fails when sense_mv_i is strictly below the threshold.
- R7: A line code below 122 gives a threshold of 50 mV, and one above 366 gives 100 mV.
- R8: `gate_o` goes low in the same cycle that `fault_o` rises. `fault_o` then stays 1, and `gate_o` stays 0, until `rst_n` is asserted, whatever the other inputs do.
- R9: While `fault_o` is 0, `gate_o` equals `gate_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_i | input | 1 | Gate command from the modulator |
| sense_mv_i | input | MV_W (10) | Sense level in mV |
| line_v_i | input | LINE_W (9) | Line DC voltage in V |
| gate_o | output | 1 | Gate command passed on, forced low on fault |
| fault_o | output | 1 | Sticky short-circuit fault |

## Verification
A wrong run count shows as a fault that comes one or more pulses early or late. A sample point that is off by one cycle shows as pulses one cycle longer or shorter than SAMPLE_DLY+1 being judged wrongly. A miscomputed threshold moves the pass/fail boundary by a millivolt at the tested line codes, so the fault then appears, or fails to appear, within one run of RUN_LEN pulses. A shutdown path that uses the registered fault one cycle late shows as a gate that is still high in the cycle the fault rises.

// File: rtl/ssg_pkg.sv
package ssg_pkg;
  // Classification of one sample slot
  typedef enum logic [1:0] {
    SMP_IDLE = 2'd0,
    SMP_PASS = 2'd1,
    SMP_FAIL = 2'd2
  } smp_kind_t;

  localparam int unsigned DEF_LINE_LO_V = 122;
  localparam int unsigned DEF_LINE_HI_V = 366;
  localparam int unsigned DEF_THR_LO_MV = 50;
  localparam int unsigned DEF_THR_HI_MV = 100;
endpackage

// File: rtl/ssg_sample_timer.sv
module ssg_sample_timer #(
  parameter int unsigned SAMPLE_DLY = 91
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_i,
  output logic strobe_o
);
  localparam int unsigned CW = $clog2(SAMPLE_DLY + 1);

  logic          gate_q;
  logic [CW-1:0] cnt_q, cnt_d;

  // next state: cnt counts cycles since the rising edge; 0 means idle
  always_comb begin
    cnt_d = cnt_q;
    if (!gate_i)                      cnt_d = '0;
    else if (!gate_q)                 cnt_d = CW'(1);
    else if (cnt_q == CW'(SAMPLE_DLY)) cnt_d = '0;
    else if (cnt_q != '0)             cnt_d = cnt_q + CW'(1);
  end

  assign strobe_o = gate_i && gate_q && (cnt_q == CW'(SAMPLE_DLY));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      gate_q <= gate_i;
      cnt_q  <= cnt_d;
    end
  end

  // at most one sample per on-pulse
  assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |=> !strobe_o);
endmodule

// File: rtl/ssg_line_threshold.sv
module ssg_line_threshold #(
  parameter int unsigned LINE_W = 9,
  parameter int unsigned MV_W   = 10,
  parameter int unsigned LO_V   = 122,
  parameter int unsigned HI_V   = 366,
  parameter int unsigned LO_MV  = 50,
  parameter int unsigned HI_MV  = 100
) (
  input  logic [LINE_W-1:0] line_i,
  output logic [MV_W-1:0]   thr_o
);
  localparam int unsigned SPAN_V  = HI_V - LO_V;
  localparam int unsigned SPAN_MV = HI_MV - LO_MV;
  localparam int unsigned PROD_W  = LINE_W + $clog2(SPAN_MV + 1);

  logic [LINE_W-1:0] offs;
  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] quot;

  always_comb begin
    offs = line_i - LINE_W'(LO_V);
    prod = PROD_W'(offs) * PROD_W'(SPAN_MV);
    quot = prod / PROD_W'(SPAN_V);
    if (line_i <= LINE_W'(LO_V))      thr_o = MV_W'(LO_MV);
    else if (line_i >= LINE_W'(HI_V)) thr_o = MV_W'(HI_MV);
    else                              thr_o = MV_W'(LO_MV) + MV_W'(quot);
  end
endmodule

// File: rtl/ssg_run_counter.sv
module ssg_run_counter
  import ssg_pkg::*;
#(
  parameter int unsigned RUN_LEN = 11,
  parameter int unsigned MV_W    = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            strobe_i,
  input  logic [MV_W-1:0] sense_i,
  input  logic [MV_W-1:0] thr_i,
  output logic            fault_o
);
  localparam int unsigned RW = $clog2(RUN_LEN + 1);

  smp_kind_t     kind;
  logic [RW-1:0] run_q, run_d;
  logic          run_en;
  logic          fault_q, fault_d;

  always_comb begin
    kind = SMP_IDLE;
    if (strobe_i) kind = (sense_i < thr_i) ? SMP_FAIL : SMP_PASS;
    run_en  = (kind != SMP_IDLE) && !fault_q;
    run_d   = (kind == SMP_FAIL) ? run_q + RW'(1) : '0;
    fault_d = fault_q || ((kind == SMP_FAIL) && (run_q == RW'(RUN_LEN - 1)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      if (run_en) run_q <= run_d;
      fault_q <= fault_d;
    end
  end

  assign fault_o = fault_q;

  assert_run_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RW'(RUN_LEN));
  assert_fault_from_fail_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_q) |-> $past(kind == SMP_FAIL));
  assert_pass_clears_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == SMP_PASS && !fault_q) |=> (run_q == '0));
  assert_fault_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |=> fault_q);
endmodule

// File: rtl/sense_short_guard.sv
module sense_short_guard
  import ssg_pkg::*;
#(
  parameter int unsigned SAMPLE_DLY = 91,
  parameter int unsigned RUN_LEN    = 11,
  parameter int unsigned LINE_W     = 9,
  parameter int unsigned MV_W       = 10,
  parameter int unsigned LINE_LO_V  = DEF_LINE_LO_V,
  parameter int unsigned LINE_HI_V  = DEF_LINE_HI_V,
  parameter int unsigned THR_LO_MV  = DEF_THR_LO_MV,
  parameter int unsigned THR_HI_MV  = DEF_THR_HI_MV
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate_i,
  input  logic [MV_W-1:0]   sense_mv_i,
  input  logic [LINE_W-1:0] line_v_i,
  output logic              gate_o,
  output logic              fault_o
);
  logic            strobe;
  logic [MV_W-1:0] thr;
  logic            fault;

  ssg_sample_timer #(.SAMPLE_DLY(SAMPLE_DLY)) u_timer (
    .clk(clk), .rst_n(rst_n), .gate_i(gate_i), .strobe_o(strobe)
  );

  ssg_line_threshold #(
    .LINE_W(LINE_W), .MV_W(MV_W), .LO_V(LINE_LO_V), .HI_V(LINE_HI_V),
    .LO_MV(THR_LO_MV), .HI_MV(THR_HI_MV)
  ) u_thr (
    .line_i(line_v_i), .thr_o(thr)
  );

  ssg_run_counter #(.RUN_LEN(RUN_LEN), .MV_W(MV_W)) u_run (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe), .sense_i(sense_mv_i),
    .thr_i(thr), .fault_o(fault)
  );

  // shutdown takes effect in the same cycle the fault register is set
  assign gate_o  = gate_i && !fault;
  assign fault_o = fault;

  assert_thr_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (thr >= MV_W'(THR_LO_MV)) && (thr <= MV_W'(THR_HI_MV)));
endmodule

// File: tb/sim_sense_short_guard.sv
module sim_sense_short_guard;
  localparam int CLK_PERIOD = 10;
  localparam int DLY        = 6;
  localparam int RUN        = 11;
  localparam int FULL       = DLY + 2;
  localparam int SHORT      = DLY;
  localparam int NVEC       = 15;

  // {line V (9), sense mV (10), expected fault (1)}
  localparam logic [19:0] VEC [NVEC] = '{
    {9'd122, 10'd49,  1'b1}, {9'd122, 10'd50,  1'b0},
    {9'd366, 10'd99,  1'b1}, {9'd366, 10'd100, 1'b0},
    {9'd244, 10'd74,  1'b1}, {9'd244, 10'd75,  1'b0},
    {9'd200, 10'd64,  1'b1}, {9'd200, 10'd65,  1'b0},
    {9'd60,  10'd49,  1'b1}, {9'd60,  10'd50,  1'b0},
    {9'd500, 10'd99,  1'b1}, {9'd500, 10'd100, 1'b0},
    {9'd0,   10'd0,   1'b1}, {9'd300, 10'd85,  1'b1},
    {9'd300, 10'd86,  1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       gate_i;
  logic [9:0] sense;
  logic [8:0] line;
  logic       gate_o;
  logic       fault_o;
  int         n_chk = 0;
  int         n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sense_short_guard #(.SAMPLE_DLY(DLY), .RUN_LEN(RUN)) u0 (
    .clk(clk), .rst_n(rst_n), .gate_i(gate_i), .sense_mv_i(sense),
    .line_v_i(line), .gate_o(gate_o), .fault_o(fault_o)
  );

  task automatic check(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n  = 1'b0;
    gate_i = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulses(input int n, input int len);
    for (int p = 0; p < n; p++) begin
      gate_i = 1'b1;
      repeat (len) @(negedge clk);
      gate_i = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    line  = 9'd122;
    sense = 10'd0;
    rst_n = 1'b0;
    gate_i = 1'b0;
    @(negedge clk);
    check(fault_o, 1'b0, "R1 fault in reset");
    do_reset();
    check(fault_o, 1'b0, "R1 fault after reset");
    gate_i = 1'b1; #1;
    check(gate_o, 1'b1, "R9 gate passes high");
    gate_i = 1'b0; #1;
    check(gate_o, 1'b0, "R9 gate passes low");

    // threshold table, R6 / R7
    for (int v = 0; v < NVEC; v++) begin
      do_reset();
      line  = VEC[v][19:11];
      sense = VEC[v][10:1];
      pulses(RUN, FULL);
      check(fault_o, VEC[v][0], $sformatf("R6/R7 vec %0d line=%0d sense=%0d", v, line, sense));
    end

    // R3: RUN-1 failures do not trip, RUN do
    do_reset();
    line = 9'd200; sense = 10'd10;
    pulses(RUN - 1, FULL);
    check(fault_o, 1'b0, "R3 one short of run");
    pulses(1, FULL);
    check(fault_o, 1'b1, "R3 full run");

    // R2: pulse of exactly DLY+1 cycles is judged
    do_reset();
    pulses(RUN, DLY + 1);
    check(fault_o, 1'b1, "R2 minimum judged pulse");

    // R5: short pulses alone never trip
    do_reset();
    pulses(2 * RUN, SHORT);
    check(fault_o, 1'b0, "R5 short pulses ignored");
    // R5: short pulses inside a run do not reset it
    do_reset();
    pulses(5, FULL); pulses(3, SHORT); pulses(5, FULL);
    check(fault_o, 1'b0, "R5 run of ten with gaps");
    pulses(1, FULL);
    check(fault_o, 1'b1, "R5 run continues over short pulses");

    // R4: one passing sample restarts the run
    do_reset();
    pulses(RUN - 1, FULL);
    sense = 10'd500; pulses(1, FULL);
    sense = 10'd10;  pulses(RUN - 1, FULL);
    check(fault_o, 1'b0, "R4 run restarted by pass");
    pulses(1, FULL);
    check(fault_o, 1'b1, "R4 full run after restart");

    // R8: same-cycle shutdown
    do_reset();
    pulses(RUN - 1, FULL);
    gate_i = 1'b1;
    repeat (DLY) @(negedge clk);
    check(fault_o, 1'b0, "R8 before sample point");
    check(gate_o, 1'b1, "R9 gate high before sample point");
    @(negedge clk);
    check(fault_o, 1'b1, "R8 fault at sample point");
    check(gate_o, 1'b0, "R8 gate cut in same cycle");
    gate_i = 1'b0;
    repeat (3) @(negedge clk);
    // R8: sticky despite passing samples
    sense = 10'd500;
    pulses(3, FULL);
    check(fault_o, 1'b1, "R8 fault sticky");
    gate_i = 1'b1; #1;
    check(gate_o, 1'b0, "R8 gate held low");
    gate_i = 1'b0;
    do_reset();
    check(fault_o, 1'b0, "R1 reset clears fault");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule